// File: doc/BRIEF.md
# Rising-Edge Phase Aligner

This block keeps two clocks of equal frequency aligned on their rising edges. One input is the divided core clock, the reference. The other is the divided channel clock, which returns after passing through an external delay line and a fixed loop delay. Both inputs are sampled by a fast local clock. The block measures, in sample-clock cycles, which rising edge arrived first and by how much. It then steps a saturating phase-select code up or down by one. That code drives the delay line, which closes the loop.

Each comparison pairs one reference rising edge with one channel rising edge inside a window of about one input period. Falling edges play no part, so the two inputs may have different duty cycles. A separation no larger than the deadband counts as aligned. A run of aligned comparisons, whose length is programmable, raises a lock flag. When no edges arrive (inputs tied low), or when the aligner is bypassed by the hold input, the code stays where it is.

Top module: `phase_aligner`

## Requirements
- R1: After reset the code is CODE_RESET (32 with the default 6-bit code), and lock_o, early_o and late_o are all 0.
- R2: When the channel rising edge precedes the reference rising edge by more than DEADBAND sample cycles (default 1), one comparison raises the code by exactly 1. It also sets early_o=1 and late_o=0.
- R3: When the reference rising edge precedes the channel rising edge by more than DEADBAND cycles, one comparison lowers the code by exactly 1. It also sets late_o=1 and early_o=0.
- R4: When the two rising edges are at most DEADBAND cycles apart, including the same cycle, the code is unchanged and early_o and late_o are both 0.
- R5: Only rising edges are compared. A high time of 25%, 50% or 75% of the period on either input, in any combination, gives the same result as any other.
- R6: Any separation up to just under half of the input period (up to 9 cycles for a 20-cycle period) is resolved in the correct direction.
- R7: With both inputs held low, or with only one input toggling, the code and the flags do not change.
- R8: While hold_i is 1, comparisons have no effect: code_o, early_o, late_o and lock_o keep their values.
- R9: The code saturates at 0 and at 2^CODE_W-1 and never wraps.
- R10: lock_o rises on the comparison that completes lock_need_i consecutive in-band comparisons.
- R11: A single out-of-band comparison clears lock_o and restarts the in-band count.
- R12: The code changes by at most one step per comparison and per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, much faster than the compared clocks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_div_i | input | 1 | Divided core clock (reference) |
| chan_div_i | input | 1 | Divided channel clock (delayed by the code) |
| hold_i | input | 1 | Bypass/test: freeze code and flags |
| lock_need_i | input | LOCK_W | Consecutive in-band comparisons needed for lock |
| code_o | output | CODE_W | Phase-select code for the delay line |
| early_o | output | 1 | Last comparison: channel edge early, out of band |
| late_o | output | 1 | Last comparison: channel edge late, out of band |
| lock_o | output | 1 | Loop locked |

## Verification
The bench sweeps every separation from 9 cycles early to 9 cycles late against all nine duty-cycle pairings. A design that looked at falling edges, or that mis-paired edges near half a period, would step the wrong way for some pair. Saturation runs drive the code into both rails, where a wrapping counter would jump to the far end. Idle, one-sided and held stimulus check that a design which steps on timeouts, or ignores hold, leaves the code where it was. A closed-loop run models the delay line from the code and expects convergence into the deadband and lock. A single late comparison afterwards must drop lock.

// File: rtl/phase_align_pkg.sv
package phase_align_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_WAIT_C = 2'd1,  // channel seen, waiting for reference
    ARB_WAIT_R = 2'd2   // reference seen, waiting for channel
  } arb_state_e;

endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pa_arbiter.sv
module pa_arbiter
  import phase_align_pkg::*;
#(
  parameter int WINDOW = 32,
  parameter int DIST_W = $clog2(WINDOW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_ref,
  input  logic              rise_chn,
  output logic              res_vld_o,
  output logic              res_chn_first_o,
  output logic [DIST_W-1:0] res_dist_o
);

  localparam logic [DIST_W-1:0] CNT_LAST = DIST_W'(WINDOW - 1);
  localparam logic [DIST_W-1:0] CNT_ONE  = DIST_W'(1);

  arb_state_e        state_q, state_d;
  logic [DIST_W-1:0] cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic              cfirst_q, cfirst_d;
  logic [DIST_W-1:0] dist_q, dist_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    vld_d    = 1'b0;
    cfirst_d = cfirst_q;
    dist_d   = dist_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (rise_ref && rise_chn) begin
          vld_d    = 1'b1;
          cfirst_d = 1'b0;
          dist_d   = '0;
        end else if (rise_ref) begin
          state_d = ARB_WAIT_R;
          cnt_d   = CNT_ONE;
        end else if (rise_chn) begin
          state_d = ARB_WAIT_C;
          cnt_d   = CNT_ONE;
        end
      end
      ARB_WAIT_R: begin
        if (rise_chn) begin
          vld_d    = 1'b1;
          cfirst_d = 1'b0;
          dist_d   = cnt_q;
          state_d  = ARB_IDLE;
        end else if (rise_ref) begin
          cnt_d = CNT_ONE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ARB_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ARB_WAIT_C: begin
        if (rise_ref) begin
          vld_d    = 1'b1;
          cfirst_d = 1'b1;
          dist_d   = cnt_q;
          state_d  = ARB_IDLE;
        end else if (rise_chn) begin
          cnt_d = CNT_ONE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ARB_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ARB_IDLE;
      cnt_q    <= '0;
      vld_q    <= 1'b0;
      cfirst_q <= 1'b0;
      dist_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      vld_q    <= vld_d;
      cfirst_q <= cfirst_d;
      dist_q   <= dist_d;
    end
  end

  assign res_vld_o       = vld_q;
  assign res_chn_first_o = cfirst_q;
  assign res_dist_o      = dist_q;

endmodule

// File: rtl/pa_stepper.sv
module pa_stepper #(
  parameter int CODE_W     = 6,
  parameter int CODE_RESET = 32,
  parameter int DIST_W     = 5,
  parameter int DEADBAND   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic              res_chn_first,
  input  logic [DIST_W-1:0] res_dist,
  input  logic              hold,
  output logic [CODE_W-1:0] code_o,
  output logic              early_o,
  output logic              late_o,
  output logic              cmp_vld_o,
  output logic              cmp_in_band_o
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(CODE_RESET);
  localparam logic [CODE_W-1:0] CODE_ONE  = CODE_W'(1);
  localparam logic [DIST_W-1:0] DB_L      = DIST_W'(DEADBAND);

  logic [CODE_W-1:0] code_q, code_d;
  logic              early_q, early_d;
  logic              late_q, late_d;
  logic              upd_en;
  logic              in_band;

  assign upd_en  = res_vld & ~hold;
  assign in_band = (res_dist <= DB_L);

  always_comb begin
    code_d  = code_q;
    early_d = early_q;
    late_d  = late_q;
    if (upd_en) begin
      early_d = ~in_band & res_chn_first;
      late_d  = ~in_band & ~res_chn_first;
      if (!in_band) begin
        if (res_chn_first) begin
          if (code_q != CODE_MAX) code_d = code_q + CODE_ONE;
        end else begin
          if (code_q != '0) code_d = code_q - CODE_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_INIT;
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else if (upd_en) begin
      code_q  <= code_d;
      early_q <= early_d;
      late_q  <= late_d;
    end
  end

  assign code_o        = code_q;
  assign early_o       = early_q;
  assign late_o        = late_q;
  assign cmp_vld_o     = upd_en;
  assign cmp_in_band_o = in_band;

endmodule

// File: rtl/pa_lock.sv
module pa_lock #(
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_vld,
  input  logic              cmp_in_band,
  input  logic [LOCK_W-1:0] lock_need,
  output logic              lock_o
);

  localparam logic [LOCK_W-1:0] RUN_ONE = LOCK_W'(1);

  logic [LOCK_W-1:0] run_q, run_d;
  logic [LOCK_W-1:0] run_inc;
  logic              lock_q, lock_d;

  assign run_inc = (run_q == {LOCK_W{1'b1}}) ? run_q : run_q + RUN_ONE;

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    if (cmp_vld) begin
      if (cmp_in_band) begin
        run_d  = run_inc;
        lock_d = (run_inc >= lock_need);
      end else begin
        run_d  = '0;
        lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (cmp_vld) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/phase_aligner.sv
module phase_aligner #(
  parameter int CODE_W      = 6,
  parameter int CODE_RESET  = 32,
  parameter int WINDOW      = 32,
  parameter int DEADBAND    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_div_i,
  input  logic              chan_div_i,
  input  logic              hold_i,
  input  logic [LOCK_W-1:0] lock_need_i,
  output logic [CODE_W-1:0] code_o,
  output logic              early_o,
  output logic              late_o,
  output logic              lock_o
);

  localparam int DIST_W = $clog2(WINDOW);
  localparam int N_IN   = 2;

  logic [1:0]      rst_pipe_q;
  logic            rst_n_int;
  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise;
  logic              res_vld;
  logic              res_chn_first;
  logic [DIST_W-1:0] res_dist;
  logic              cmp_vld;
  logic              cmp_in_band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign raw_in = {chan_div_i, core_div_i};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .din    (raw_in[gi]),
      .rise_o (rise[gi])
    );
  end

  pa_arbiter #(.WINDOW(WINDOW), .DIST_W(DIST_W)) u_arb (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .rise_ref        (rise[0]),
    .rise_chn        (rise[1]),
    .res_vld_o       (res_vld),
    .res_chn_first_o (res_chn_first),
    .res_dist_o      (res_dist)
  );

  pa_stepper #(
    .CODE_W(CODE_W), .CODE_RESET(CODE_RESET),
    .DIST_W(DIST_W), .DEADBAND(DEADBAND)
  ) u_step (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .res_vld       (res_vld),
    .res_chn_first (res_chn_first),
    .res_dist      (res_dist),
    .hold          (hold_i),
    .code_o        (code_o),
    .early_o       (early_o),
    .late_o        (late_o),
    .cmp_vld_o     (cmp_vld),
    .cmp_in_band_o (cmp_in_band)
  );

  pa_lock #(.LOCK_W(LOCK_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cmp_vld     (cmp_vld),
    .cmp_in_band (cmp_in_band),
    .lock_need   (lock_need_i),
    .lock_o      (lock_o)
  );

endmodule

// File: rtl/phase_aligner_chk.sv
module phase_aligner_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_i,
  input logic [CODE_W-1:0] code_o,
  input logic              early_o,
  input logic              late_o,
  input logic              lock_o
);

  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CONE = CODE_W'(1);

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> ((code_o == $past(code_o) + CONE) || (code_o == $past(code_o) - CONE))); // R12

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(code_o) && $stable(lock_o) && $stable(early_o) && $stable(late_o))); // R8

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({early_o, late_o})); // R4

  AST_MISS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (early_o || late_o) |-> !lock_o); // R11

  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == CMAX) |=> (code_o != '0)); // R9

  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |=> (code_o != CMAX)); // R9

endmodule

bind phase_aligner phase_aligner_chk #(.CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hold_i (hold_i),
  .code_o (code_o),
  .early_o(early_o),
  .late_o (late_o),
  .lock_o (lock_o)
);

// File: tb/tb_phase_aligner.sv
module tb_phase_aligner;

  localparam int CODE_W = 6;
  localparam int CRST   = 32;
  localparam int CMAX   = 63;
  localparam int DB     = 1;
  localparam int SLOT   = 48;
  localparam int EDGE0  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic core_div, chan_div, hold;
  logic [3:0] need;
  logic [CODE_W-1:0] code;
  logic early, late, lock;

  int n_chk = 0, n_fail = 0;
  int m_code, m_run, m_lock, m_early, m_late;
  bit done = 0;

  always #5 clk = ~clk;

  phase_aligner dut (
    .clk(clk), .rst_n(rst_n), .core_div_i(core_div), .chan_div_i(chan_div),
    .hold_i(hold), .lock_need_i(need), .code_o(code), .early_o(early),
    .late_o(late), .lock_o(lock)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " code"}, int'(code), m_code);
    check({req, " early"}, int'(early), m_early);
    check({req, " late"}, int'(late), m_late);
    check({req, " lock"}, int'(lock), m_lock);
  endtask

  task automatic do_reset();
    core_div = 0; chan_div = 0; hold = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_code = CRST; m_run = 0; m_lock = 0; m_early = 0; m_late = 0;
  endtask

  // off > 0: channel edge late; off < 0: channel edge early
  task automatic drive_slot(int off, int hia, int hib);
    for (int c = 0; c < SLOT; c++) begin
      @(negedge clk);
      core_div = (c >= EDGE0) && (c < EDGE0 + hia);
      chan_div = (c >= EDGE0 + off) && (c < EDGE0 + off + hib);
    end
  endtask

  task automatic model(int off);
    int mag;
    mag = (off < 0) ? -off : off;
    if (hold) return;
    if (mag > DB) begin
      if (off < 0) m_code = (m_code == CMAX) ? CMAX : m_code + 1;
      else         m_code = (m_code == 0) ? 0 : m_code - 1;
      m_early = (off < 0); m_late = (off > 0);
      m_run = 0; m_lock = 0;
    end else begin
      m_early = 0; m_late = 0;
      m_run = (m_run == 15) ? 15 : m_run + 1;
      m_lock = (m_run >= int'(need));
    end
  endtask

  task automatic slot_chk(string req, int off, int hia, int hib);
    drive_slot(off, hia, hib);
    model(off);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int prev;
    need = 4'd4;
    do_reset();
    check_all("R1 reset");

    // R2/R3/R4 direction sweep with every duty pairing (R5) up to half period (R6)
    for (int off = -9; off <= 9; off++) begin
      for (int da = 1; da <= 3; da++) begin
        for (int dbt = 1; dbt <= 3; dbt++) begin
          string rq;
          rq = (off < -DB) ? "R2/R5/R6" : ((off > DB) ? "R3/R5/R6" : "R4/R5");
          slot_chk(rq, off, 5 * da, 5 * dbt);
        end
      end
    end

    // R12: one comparison moves exactly one step
    prev = int'(code);
    slot_chk("R12", -9, 10, 10);
    check("R12 single step", int'(code) - prev, (prev == CMAX) ? 0 : 1);

    // R7: idle and one-sided inputs
    prev = int'(code);
    drive_slot(0, 0, 0);
    drive_slot(0, 0, 0);
    check_all("R7 idle");
    drive_slot(3, 10, 0);
    drive_slot(3, 10, 0);
    check_all("R7 reference only");
    drive_slot(-3, 0, 10);
    drive_slot(-3, 0, 10);
    check_all("R7 channel only");

    // R8: hold freezes
    @(negedge clk); hold = 1;
    for (int k = 0; k < 3; k++) slot_chk("R8 hold", -6, 10, 10);
    for (int k = 0; k < 3; k++) slot_chk("R8 hold", 6, 10, 10);
    @(negedge clk); hold = 0;
    repeat (8) @(negedge clk);
    check_all("R8 after hold");

    // R9: saturation both rails
    do_reset();
    for (int k = 0; k < 40; k++) slot_chk("R9 top", -5, 10, 10);
    check("R9 max", int'(code), CMAX);
    for (int k = 0; k < 70; k++) slot_chk("R9 bottom", 5, 10, 10);
    check("R9 min", int'(code), 0);

    // R10/R11: lock count and drop
    do_reset();
    for (int k = 0; k < 3; k++) slot_chk("R10 pre-lock", 0, 10, 10);
    check("R10 not yet", int'(lock), 0);
    slot_chk("R10 lock", 1, 10, 10);
    check("R10 locked", int'(lock), 1);
    slot_chk("R11 drop", 3, 10, 10);
    check("R11 unlocked", int'(lock), 0);
    @(negedge clk); need = 4'd1;
    slot_chk("R10 need1", -1, 10, 10);
    check("R10 need1 locked", int'(lock), 1);

    // R10 closed loop: delay line adds one cycle per code step
    for (int base = -8; base <= 8; base += 16) begin
      int off;
      do_reset();
      @(negedge clk); need = 4'd4;
      for (int k = 0; k < 20; k++) begin
        off = base + int'(code) - CRST;
        slot_chk("R10 loop", off, 10, 10);
      end
      off = base + int'(code) - CRST;
      check("R10 loop residual", (off < -DB || off > DB) ? 1 : 0, 0);
      check("R10 loop lock", int'(lock), 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule